// File: doc/BRIEF.md
# Prioritised Vectoring Interrupt Controller

This block collects up to thirteen level-sensitive interrupt requests, numbered 1 to 13, and turns them into a single request to the processor: a 3-bit priority level and an 8-bit exception vector. Each source has a pending bit that tracks its input, a mask bit, and a control byte. The control byte carries a 5-bit arbitration key whose upper three bits form the presented level, and an autovector flag.

Each cycle the controller compares the keys of all unmasked pending sources. The largest key wins, and on equal keys the lowest source number wins. When the winning key has a zero level field, nothing is presented. Otherwise the vector is 24 plus the level when the autovector flag is set. When the flag is clear, the vector comes from one of three programmable vector registers (watchdog, serial port A, serial port B) or from a fixed fallback value.

Software reaches every register through a simple byte-wide port: a write strobe with an address and data, and a combinational read path. The block also holds a write-one-to-clear reset-status byte. The level and vector outputs are registered.

Top module: `irq_prio_vectorer`

## Requirements
- R1: Pending bit n captures input n at every clock edge. Pending bits are read at 0x3A (bits 15:8) and 0x3B (bits 7:0), with bit n standing for source n and bits 0, 14 and 15 reading 0. Writes to these two addresses change nothing.
- R2: Only sources with pending 1 and mask 0 take part in arbitration, where a mask bit of 1 means masked. The mask resets to 0x3FFE. It is read and written at 0x36 (bits 15:8) and 0x37 (bits 7:0), using the same bit layout as the pending bits. Mask bits 0, 14 and 15 always read 0 and ignore writes.
- R3: The arbitration key is bits 4:0 of a source's control byte. The winner has the strictly largest key, and equal keys go to the lower source number.
- R4: If the winning key is below 4, or no source takes part, the level output is 0 and the vector output is 0.
- R5: The presented level is bits 4:2 of the winner's control byte.
- R6: If bit 7 of the winner's control byte is 1, the vector is 24 plus the level.
- R7: With bit 7 clear, the vector depends on the winning source: source 8 uses the watchdog vector register (0x42), source 12 uses the serial-A vector register (0x44), source 13 uses the serial-B vector register (0x45), and any other source gives 0x0F.
- R8: The control byte of source n is at address 0x13+n and can be read and written. After reset, sources 1 to 7 hold 4·n, source 8 holds 0x1C, sources 9 to 11 hold 0x80, and sources 12 and 13 hold 0x00.
- R9: The reset-status byte at 0x40 resets to 0x80. Writing to it clears each bit that is 1 in the written data and leaves the other bits unchanged.
- R10: The watchdog and both serial vector registers reset to 0x0F. Address 0x41 and any unmapped address read 0, and writes to unmapped addresses change no register.
- R11: The level and vector outputs are registered. A change on an input reaches them after two clock edges: one edge into the pending bit, then one edge into the output. A register write reaches them one edge after the edge that performs the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt request levels; bit n is source n |
| reg_we | input | 1 | Byte write strobe |
| reg_addr | input | 8 | Byte address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |
| ipl_o | output | 3 | Presented interrupt level, 0 when idle |
| vec_o | output | 8 | Presented vector, 0 when idle |

## Verification
The bench builds the block with its default parameters: thirteen sources, the watchdog vector on source 8, and the serial vectors on sources 12 and 13. With these values every vector path can be reached. That covers the autovector flag, each of the three programmable registers, the fallback value, and the suppression of low keys on sources 9 to 13, whose reset control bytes have a zero level field. The table of source patterns covers ties between equal keys and mixes of suppressed and valid sources. Directed tests then measure the exact edge on which a change appears at the outputs.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int ADDR_W     = 8;
  localparam int KEY_W      = 5;
  localparam int MASK_W     = 16;
  localparam logic [7:0] A_CTL_BASE = 8'h14;
  localparam logic [7:0] A_MASK_HI  = 8'h36;
  localparam logic [7:0] A_MASK_LO  = 8'h37;
  localparam logic [7:0] A_PEND_HI  = 8'h3A;
  localparam logic [7:0] A_PEND_LO  = 8'h3B;
  localparam logic [7:0] A_RSTAT    = 8'h40;
  localparam logic [7:0] A_WDOG_VEC = 8'h42;
  localparam logic [7:0] A_SERA_VEC = 8'h44;
  localparam logic [7:0] A_SERB_VEC = 8'h45;
  localparam logic [7:0] VEC_RESET  = 8'h0F;
  localparam logic [7:0] RSTAT_INIT = 8'h80;

  // Power-up control byte of source n.
  function automatic logic [7:0] ctl_reset(input int n);
    if (n >= 1 && n <= 7)       return 8'(n * 4);
    else if (n == 8)            return 8'h1C;
    else if (n >= 9 && n <= 11) return 8'h80;
    else                        return 8'h00;
  endfunction
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_SRC:1]         src_i,
  input  logic                     reg_we,
  input  logic [ADDR_W-1:0]        reg_addr,
  input  logic [7:0]               reg_wdata,
  output logic [7:0]               reg_rdata,
  output logic [NUM_SRC:1][7:0]    ctl_o,
  output logic [NUM_SRC:1]         mask_o,
  output logic [NUM_SRC:1]         pend_o,
  output logic [7:0]               wdog_vec_o,
  output logic [7:0]               sera_vec_o,
  output logic [7:0]               serb_vec_o,
  output logic [7:0]               rstat_o
);
  logic [MASK_W-1:0] mask_full, pend_full, mask_next;

  assign mask_full = MASK_W'({mask_o, 1'b0});
  assign pend_full = MASK_W'({pend_o, 1'b0});

  // Pending bits follow the request levels.
  always_ff @(posedge clk) begin
    if (!rst_n) pend_o <= '0;
    else        pend_o <= src_i;
  end

  // Control bytes, one register per source.
  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_ctl
    localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(int'(A_CTL_BASE) + g - 1);
    always_ff @(posedge clk) begin
      if (!rst_n)                              ctl_o[g] <= ctl_reset(g);
      else if (reg_we && reg_addr == CTL_ADDR) ctl_o[g] <= reg_wdata;
    end
  end

  always_comb begin
    mask_next = mask_full;
    if (reg_addr == A_MASK_HI) mask_next[15:8] = reg_wdata;
    else                       mask_next[7:0]  = reg_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_o     <= '1;
      wdog_vec_o <= VEC_RESET;
      sera_vec_o <= VEC_RESET;
      serb_vec_o <= VEC_RESET;
      rstat_o    <= RSTAT_INIT;
    end else if (reg_we) begin
      unique case (reg_addr)
        A_MASK_HI, A_MASK_LO: mask_o <= mask_next[NUM_SRC:1];
        A_WDOG_VEC: wdog_vec_o <= reg_wdata;
        A_SERA_VEC: sera_vec_o <= reg_wdata;
        A_SERB_VEC: serb_vec_o <= reg_wdata;
        A_RSTAT:    rstat_o    <= rstat_o & ~reg_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    unique case (reg_addr)
      A_MASK_HI:  reg_rdata = mask_full[15:8];
      A_MASK_LO:  reg_rdata = mask_full[7:0];
      A_PEND_HI:  reg_rdata = pend_full[15:8];
      A_PEND_LO:  reg_rdata = pend_full[7:0];
      A_RSTAT:    reg_rdata = rstat_o;
      A_WDOG_VEC: reg_rdata = wdog_vec_o;
      A_SERA_VEC: reg_rdata = sera_vec_o;
      A_SERB_VEC: reg_rdata = serb_vec_o;
      default: ;
    endcase
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (reg_addr == ADDR_W'(int'(A_CTL_BASE) + i - 1)) reg_rdata = ctl_o[i];
    end
  end
endmodule

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
#(
  parameter int NUM_SRC = 13,
  localparam int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic [NUM_SRC:1]      pend_i,
  input  logic [NUM_SRC:1]      mask_i,
  input  logic [NUM_SRC:1][7:0] ctl_i,
  output logic                  win_valid_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic [7:0]            win_ctl_o
);
  logic [NUM_SRC:1] active;
  logic [KEY_W-1:0] best;

  assign active = pend_i & ~mask_i;

  // Upward scan with a strict compare: lower index keeps a tie.
  always_comb begin
    best      = '0;
    win_idx_o = '0;
    win_ctl_o = 8'h00;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (active[i] && ctl_i[i][KEY_W-1:0] > best) begin
        best      = ctl_i[i][KEY_W-1:0];
        win_idx_o = IDX_W'(i);
        win_ctl_o = ctl_i[i];
      end
    end
    win_valid_o = best[KEY_W-1:2] != '0;
  end
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector #(
  parameter int         NUM_SRC   = 13,
  parameter int         WDOG_SRC  = 8,
  parameter int         SERA_SRC  = 12,
  parameter int         SERB_SRC  = 13,
  parameter logic [7:0] AUTO_BASE = 8'd24,
  parameter logic [7:0] FALLBACK  = 8'h0F,
  localparam int IDX_W = $clog2(NUM_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic [7:0]       win_ctl_i,
  input  logic [7:0]       wdog_vec_i,
  input  logic [7:0]       sera_vec_i,
  input  logic [7:0]       serb_vec_i,
  output logic [2:0]       ipl_o,
  output logic [7:0]       vec_o
);
  logic [2:0] lvl_d;
  logic [7:0] vec_d;

  always_comb begin
    lvl_d = 3'd0;
    vec_d = 8'h00;
    if (win_valid_i) begin
      lvl_d = win_ctl_i[4:2];
      if (win_ctl_i[7])                       vec_d = AUTO_BASE + 8'(lvl_d);
      else if (win_idx_i == IDX_W'(WDOG_SRC)) vec_d = wdog_vec_i;
      else if (win_idx_i == IDX_W'(SERA_SRC)) vec_d = sera_vec_i;
      else if (win_idx_i == IDX_W'(SERB_SRC)) vec_d = serb_vec_i;
      else                                    vec_d = FALLBACK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ipl_o <= 3'd0;
      vec_o <= 8'h00;
    end else begin
      ipl_o <= lvl_d;
      vec_o <= vec_d;
    end
  end
endmodule

// File: rtl/irq_prio_vectorer.sv
module irq_prio_vectorer
  import irqv_pkg::*;
#(
  parameter int NUM_SRC  = 13,
  parameter int WDOG_SRC = 8,
  parameter int SERA_SRC = 12,
  parameter int SERB_SRC = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   src_i,
  input  logic               reg_we,
  input  logic [7:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  output logic [2:0]         ipl_o,
  output logic [7:0]         vec_o
);
  localparam int IDX_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1][7:0] ctl_w;
  logic [NUM_SRC:1]      mask_w, pend_w;
  logic [7:0]            wdog_vec_w, sera_vec_w, serb_vec_w, rstat_w;
  logic                  win_valid_w;
  logic [IDX_W-1:0]      win_idx_w;
  logic [7:0]            win_ctl_w;

  irqv_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ctl_o(ctl_w), .mask_o(mask_w), .pend_o(pend_w),
    .wdog_vec_o(wdog_vec_w), .sera_vec_o(sera_vec_w), .serb_vec_o(serb_vec_w),
    .rstat_o(rstat_w)
  );

  irqv_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
    .pend_i(pend_w), .mask_i(mask_w), .ctl_i(ctl_w),
    .win_valid_o(win_valid_w), .win_idx_o(win_idx_w), .win_ctl_o(win_ctl_w)
  );

  irqv_vector #(
    .NUM_SRC(NUM_SRC), .WDOG_SRC(WDOG_SRC),
    .SERA_SRC(SERA_SRC), .SERB_SRC(SERB_SRC)
  ) u_vec (
    .clk(clk), .rst_n(rst_n),
    .win_valid_i(win_valid_w), .win_idx_i(win_idx_w), .win_ctl_i(win_ctl_w),
    .wdog_vec_i(wdog_vec_w), .sera_vec_i(sera_vec_w), .serb_vec_i(serb_vec_w),
    .ipl_o(ipl_o), .vec_o(vec_o)
  );
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker #(
  parameter int NUM_SRC = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NUM_SRC:1] src_i,
  input logic [NUM_SRC:1] pend,
  input logic [NUM_SRC:1] mask,
  input logic [7:0]       rstat,
  input logic [2:0]       ipl_o,
  input logic [7:0]       vec_o
);
  p_pend_tracks_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> pend == $past(src_i));

  p_idle_without_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past((pend & ~mask) == '0)) |-> ipl_o == 3'd0);

  p_no_vector_at_level0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ipl_o == 3'd0 |-> vec_o == 8'h00);

  p_rstat_never_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rstat & ~$past(rstat)) == 8'h00);
endmodule

bind irq_prio_vectorer irqv_checker #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_i(src_i), .pend(pend_w), .mask(mask_w),
  .rstat(rstat_w), .ipl_o(ipl_o), .vec_o(vec_o)
);

// File: tb/irq_prio_vectorer_bench.sv
module irq_prio_vectorer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] src = '0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [2:0]  ipl;
  logic [7:0]  vec;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_vectorer u_irq_prio_vectorer (
    .clk(clk), .rst_n(rst_n), .src_i(src), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .ipl_o(ipl), .vec_o(vec)
  );

  // {sources 13..1, expected level, expected vector}; mask cleared, watchdog vector 0x40.
  localparam logic [23:0] TBL [8] = '{
    {13'h0001, 3'd1, 8'h0F},   // R5 lone source 1
    {13'h00C0, 3'd7, 8'h0F},   // R3 tie 7/8 -> 7
    {13'h0080, 3'd7, 8'h40},   // R7 watchdog vector
    {13'h0100, 3'd0, 8'h00},   // R4 key 0 suppressed
    {13'h0014, 3'd5, 8'h0F},   // R3 larger key wins
    {13'h0800, 3'd0, 8'h00},   // R4 source 12 key 0
    {13'h0000, 3'd0, 8'h00},   // R4 nothing pending
    {13'h0902, 3'd2, 8'h0F}    // R3 valid beats suppressed
  };

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    addr = a; #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %h: got %h expected %h", tag, a, rdata, exp);
    end
  endtask

  task automatic out(input logic [2:0] el, input logic [7:0] ev, input string tag);
    n_chk++;
    if (ipl !== el || vec !== ev) begin
      n_fail++;
      $display("FAIL %s: got level %0d vector %h expected level %0d vector %h",
               tag, ipl, vec, el, ev);
    end
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    out(3'd0, 8'h00, "R4 reset outputs");
    rd(8'h36, 8'h3F, "R2 mask reset hi");
    rd(8'h37, 8'hFE, "R2 mask reset lo");
    rd(8'h40, 8'h80, "R9 status reset");
    rd(8'h42, 8'h0F, "R10 watchdog vector reset");
    rd(8'h44, 8'h0F, "R10 serial A vector reset");
    rd(8'h45, 8'h0F, "R10 serial B vector reset");
    rd(8'h41, 8'h00, "R10 0x41 reads zero");
    rd(8'h14, 8'h04, "R8 ctl1 reset");
    rd(8'h1A, 8'h1C, "R8 ctl7 reset");
    rd(8'h1B, 8'h1C, "R8 ctl8 reset");
    rd(8'h1C, 8'h80, "R8 ctl9 reset");
    rd(8'h20, 8'h00, "R8 ctl13 reset");

    // Default mask blocks everything.
    src = 13'h0001; settle();
    out(3'd0, 8'h00, "R2 reset mask blocks");
    rd(8'h3B, 8'h02, "R1 pending lo");
    wr(8'h3B, 8'h00);
    rd(8'h3B, 8'h02, "R1 pending read-only");

    wr(8'h36, 8'hFF); wr(8'h37, 8'hFF);
    rd(8'h36, 8'h3F, "R2 bits 15:14 ignore writes");
    rd(8'h37, 8'hFE, "R2 bit 0 ignores writes");
    wr(8'h36, 8'h00); wr(8'h37, 8'h00);
    rd(8'h37, 8'h00, "R2 mask cleared");
    wr(8'h42, 8'h40);
    src = 13'h0100; settle();
    rd(8'h3A, 8'h02, "R1 pending hi");

    for (int i = 0; i < 8; i++) begin
      src = TBL[i][23:11];
      settle();
      out(TBL[i][10:8], TBL[i][7:0], $sformatf("R3 table entry %0d", i));
    end

    // R11 input latency: two edges.
    src = '0; settle();
    src = 13'h0040;
    @(negedge clk);
    rd(8'h3B, 8'h80, "R11 pending after one edge");
    out(3'd0, 8'h00, "R11 output not yet after one edge");
    @(negedge clk);
    out(3'd7, 8'h0F, "R11 output after two edges");

    // R7 serial vectors, R6 autovector, R4 low key.
    wr(8'h44, 8'h51); wr(8'h45, 8'h52);
    wr(8'h1F, 8'h10);
    src = 13'h0800; settle();
    out(3'd4, 8'h51, "R7 serial A vector");
    wr(8'h20, 8'h0C);
    src = 13'h1000; settle();
    out(3'd3, 8'h52, "R7 serial B vector");
    wr(8'h20, 8'h8C); settle();
    out(3'd3, 8'd27, "R6 autovector level 3");
    wr(8'h1C, 8'h03);
    src = 13'h0100; settle();
    out(3'd0, 8'h00, "R4 key 3 suppressed");
    wr(8'h1C, 8'h9F); settle();
    out(3'd7, 8'd31, "R5 R6 level 7 autovector");

    // R2 masked source drops out.
    src = 13'h0041;
    wr(8'h37, 8'h80); settle();
    out(3'd1, 8'h0F, "R2 masked source 7 skipped");

    // R11 register write latency: one edge after the write edge.
    wr(8'h14, 8'h90);
    out(3'd1, 8'h0F, "R11 old output at write edge");
    @(negedge clk);
    out(3'd4, 8'd28, "R11 new output one edge later");

    // R9 write-one-to-clear; R10 unmapped.
    wr(8'h40, 8'h00);
    rd(8'h40, 8'h80, "R9 zero write keeps");
    wr(8'h40, 8'h80);
    rd(8'h40, 8'h00, "R9 one write clears");
    wr(8'h99, 8'hAA);
    rd(8'h99, 8'h00, "R10 unmapped reads zero");
    rd(8'h42, 8'h40, "R10 unmapped write ignored");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule